// File: doc/BRIEF.md
# Raw NAND Byte Transfer Engine

This block moves bytes between a register interface and an 8-bit raw NAND bus. Software picks the kind of bus phase (command, address, data out or data in) through a per-slave control word, then writes one transmit word. The byte count of that transfer, from one to four, is given by which of four transmit addresses receives the write. The engine drives those bytes onto the bus one at a time with the right latch strobe and ends each transfer with exactly one receive word. A data-in transfer also produces one receive word, and its transmit word is a dummy.

Chip enable is not tied to transfers. Software holds it through two configuration bits, so one enable window can span a whole command, address, data and wait-ready sequence. An enable bit resets the engine. Software clears it and sets it again before each command. Two status bits report whether the transmit side can accept a word and whether a receive word is waiting.

Top module: `nand_xfer_engine`

## Requirements
- R1: After reset the chip enable, write strobe and read strobe are high, the command latch, address latch and data output enable are low, the enable bit reads 0, and the status register (offset 0x04) reads 0xB. Status bits: bit0 transmit empty, bit1 transmit not full, bit2 receive word waiting, bit3 receive not full.
- R2: A write to offset 0x14, 0x18, 0x1C or 0x20 starts a transfer of 4, 1, 2 or 3 bytes respectively.
- R3: Bytes go out least significant first, so byte k is wdata[8k+7:8k]. The data output enable is high only while a driven byte is on the bus. Transmit bytes beyond the count are never driven.
- R4: Each byte takes 2·PULSE clock cycles. The strobe is low for the first PULSE of these, starting the cycle after the accepting edge, and high for the rest. The data bus holds steady while the strobe is low.
- R5: Phase comes from the control word at offset 0x30. If bits 1:0 equal 3 (8-bit command width) it is a command phase, with the command latch high while busy. Otherwise, if bits 16:14 are nonzero, it is an address phase, with the address latch high while busy. Otherwise bit 23 chooses data in (1) or data out (0).
- R6: In a data-in phase the read strobe pulses once per byte and the write strobe stays high. The bus input is sampled on the rising edge of the read strobe, and the output enable stays low.
- R7: The receive word (offset 0x24) is packed at the high end. Each new byte enters bits 31:24 and the earlier bytes move down, so an n-byte transfer leaves its first byte at bit 8·(4−n). A data-in phase captures bus bytes. A write phase returns the bytes it drove.
- R8: Status bits 0 and 1 are clear while a transfer runs. Bit 2 sets one cycle after the transfer ends and clears when offset 0x24 is read. Bit 3 is its complement.
- R9: A transmit write issued while a transfer runs is held off with reg_ready low, then accepted on the first edge after the transfer ends.
- R10: Chip enable is low exactly when configuration (offset 0x00) bit1 (manual enable) and bit0 (assert) are both set, whatever the transfers are doing.
- R11: While the enable bit (offset 0x10 bit0) is 0, transmit writes are ignored. Clearing it mid-transfer returns the strobes to idle on the next cycle and drops the waiting receive word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (consumes the receive word at 0x24) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Low while a transmit write is held off |
| reg_rdata | output | 32 | Register read data (combinational) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Bus data driven by the engine |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data from the device |

## Verification
An accepted transmit write moves the strobes low one cycle after its accepting edge. Byte k begins 2·PULSE·k cycles later, the busy status clears after 2·PULSE·n cycles, and the receive word becomes visible one edge after that. A behavioural model in the bench counts those cycles from the accepting edge on its own, and on every clock compares all bus pins 1 ns after the rising edge. Register reads are sampled mid-cycle. Each status and receive check is placed after the edge at which the model says the value has settled.

// File: rtl/nxe_pkg.sv
package nxe_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFS_CFG  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_EN   = 8'h10;
    localparam logic [REG_AW-1:0] OFS_TXB  = 8'h14;
    localparam logic [REG_AW-1:0] OFS_TXL  = 8'h20;
    localparam logic [REG_AW-1:0] OFS_RX   = 8'h24;
    localparam logic [REG_AW-1:0] OFS_CTRL = 8'h30;

    localparam logic [1:0] WIDTH_X8 = 2'd3;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DOUT = 2'd2,
        PH_DIN  = 2'd3
    } phase_e;

    // per-slave phase control word
    typedef struct packed {
        logic       rd;
        logic [5:0] dummy;
        logic [2:0] nadr;
        logic [5:0] rsvd;
        logic [1:0] dw;
        logic       ddr_a;
        logic [1:0] aw;
        logic       ddr_c;
        logic [1:0] cw;
    } ctrl_t;

    function automatic phase_e decode_phase(ctrl_t c);
        if (c.cw == WIDTH_X8)      return PH_CMD;
        else if (c.nadr != 3'd0)   return PH_ADDR;
        else if (c.rd)             return PH_DIN;
        else                       return PH_DOUT;
    endfunction

    function automatic logic is_tx_ofs(logic [REG_AW-1:0] a);
        return (a >= OFS_TXB) && (a <= OFS_TXL) && (a[1:0] == 2'b00);
    endfunction

    // slot 0 carries a full word, slots 1..3 carry that many bytes
    function automatic logic [2:0] tx_count(logic [REG_AW-1:0] a);
        logic [REG_AW-1:0] slot;
        slot = (a - OFS_TXB) >> 2;
        return (slot[1:0] == 2'd0) ? 3'd4 : {1'b0, slot[1:0]};
    endfunction

endpackage

// File: rtl/nxe_seq.sv
module nxe_seq import nxe_pkg::*; #(
    parameter int DW    = 8,
    parameter int NB    = 4,
    parameter int PULSE = 2,
    localparam int CW   = $clog2(NB + 1),
    localparam int IW   = $clog2(NB),
    localparam int PCW  = $clog2(PULSE + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  start,
    input  logic [NB-1:0][DW-1:0] word,
    input  logic [CW-1:0]         nbytes,
    input  phase_e                phase,
    input  logic [DW-1:0]         dq_in,
    output logic                  busy,
    output logic                  done,
    output logic [NB-1:0][DW-1:0] rx_word,
    output logic                  cle,
    output logic                  ale,
    output logic                  we_n,
    output logic                  re_n,
    output logic [DW-1:0]         dq_out,
    output logic                  dq_oe
);

    logic                  busy_q, half_q, done_q;
    logic [PCW-1:0]        cnt_q;
    logic [IW-1:0]         idx_q;
    logic [CW-1:0]         n_q;
    phase_e                ph_q;
    logic [NB-1:0][DW-1:0] word_q, sh_q;

    logic          strobe_low, is_rd, last_byte, pulse_end;
    logic [DW-1:0] cap_byte;

    assign is_rd      = (ph_q == PH_DIN);
    assign strobe_low = busy_q && !half_q;
    assign last_byte  = (CW'(idx_q) + CW'(1)) == n_q;
    assign pulse_end  = (cnt_q == PCW'(PULSE - 1));
    assign cap_byte   = is_rd ? dq_in : word_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy_q <= 1'b0;
            half_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            n_q    <= '0;
            ph_q   <= PH_CMD;
            word_q <= '0;
            sh_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    half_q <= 1'b0;
                    cnt_q  <= '0;
                    idx_q  <= '0;
                    n_q    <= nbytes;
                    ph_q   <= phase;
                    word_q <= word;
                    sh_q   <= '0;
                end
            end else if (!pulse_end) begin
                cnt_q <= cnt_q + PCW'(1);
            end else begin
                cnt_q <= '0;
                if (!half_q) begin
                    half_q <= 1'b1;
                    sh_q   <= {cap_byte, sh_q[NB-1:1]};
                end else if (last_byte) begin
                    busy_q <= 1'b0;
                    half_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    half_q <= 1'b0;
                    idx_q  <= idx_q + IW'(1);
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_word = sh_q;
    assign cle     = busy_q && (ph_q == PH_CMD);
    assign ale     = busy_q && (ph_q == PH_ADDR);
    assign we_n    = !(strobe_low && !is_rd);
    assign re_n    = !(strobe_low && is_rd);
    assign dq_oe   = busy_q && !is_rd;
    assign dq_out  = dq_oe ? word_q[idx_q] : '0;

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

    // R4
    we_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(dq_out));

    // R8
    done_fall_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $fell(busy_q));

endmodule

// File: rtl/nxe_regs.sv
module nxe_regs import nxe_pkg::*; #(
    parameter int DW  = 8,
    parameter int NB  = 4,
    localparam int WW = DW * NB,
    localparam int CW = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WW-1:0]     reg_wdata,
    output logic              reg_ready,
    output logic [WW-1:0]     reg_rdata,
    input  logic              seq_busy,
    input  logic              seq_done,
    input  logic [WW-1:0]     seq_rx,
    output logic              seq_start,
    output logic [WW-1:0]     seq_word,
    output logic [CW-1:0]     seq_nbytes,
    output phase_e            seq_phase,
    output logic              en,
    output logic              cs_n
);

    logic        cfg_man_q, cfg_cs_q, en_q, rx_valid_q;
    ctrl_t       ctrl_q;
    logic [WW-1:0] rx_q;
    logic        tx_hit, wr_ok;

    assign tx_hit     = reg_wr && is_tx_ofs(reg_addr);
    assign reg_ready  = !(tx_hit && seq_busy);
    assign wr_ok      = reg_wr && reg_ready;
    assign seq_start  = tx_hit && en_q && !seq_busy;
    assign seq_word   = reg_wdata;
    assign seq_nbytes = CW'(tx_count(reg_addr));
    assign seq_phase  = decode_phase(ctrl_q);
    assign en         = en_q;
    assign cs_n       = !(cfg_man_q && cfg_cs_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_man_q <= 1'b0;
            cfg_cs_q  <= 1'b0;
            en_q      <= 1'b0;
            ctrl_q    <= '0;
        end else if (wr_ok) begin
            case (reg_addr)
                OFS_CFG:  {cfg_man_q, cfg_cs_q} <= reg_wdata[1:0];
                OFS_EN:   en_q   <= reg_wdata[0];
                OFS_CTRL: ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_q       <= '0;
        end else if (!en_q) begin
            rx_valid_q <= 1'b0;
        end else if (seq_done) begin
            rx_valid_q <= 1'b1;
            rx_q       <= seq_rx;
        end else if (reg_rd && reg_addr == OFS_RX) begin
            rx_valid_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:  reg_rdata[1:0] = {cfg_man_q, cfg_cs_q};
            OFS_STAT: reg_rdata[3:0] = {~rx_valid_q, rx_valid_q, ~seq_busy, ~seq_busy};
            OFS_EN:   reg_rdata[0]   = en_q;
            OFS_RX:   reg_rdata      = rx_q;
            OFS_CTRL: reg_rdata[$bits(ctrl_t)-1:0] = ctrl_q;
            default: ;
        endcase
    end

    // R8
    rx_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_valid_q) |-> $past(seq_done));

    // R11
    dis_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !seq_busy);

endmodule

// File: rtl/nand_xfer_engine.sv
module nand_xfer_engine import nxe_pkg::*; #(
    parameter int DW    = 8,
    parameter int NB    = 4,
    parameter int PULSE = 2,
    localparam int WW   = DW * NB,
    localparam int CW   = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WW-1:0]     reg_wdata,
    output logic              reg_ready,
    output logic [WW-1:0]     reg_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DW-1:0]     nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [DW-1:0]     nand_dq_in
);

    logic          busy, done, start, en;
    logic [WW-1:0] rx_word, tx_word;
    logic [CW-1:0] nbytes;
    phase_e        phase;

    nxe_regs #(.DW(DW), .NB(NB)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ready  (reg_ready),
        .reg_rdata  (reg_rdata),
        .seq_busy   (busy),
        .seq_done   (done),
        .seq_rx     (rx_word),
        .seq_start  (start),
        .seq_word   (tx_word),
        .seq_nbytes (nbytes),
        .seq_phase  (phase),
        .en         (en),
        .cs_n       (nand_ce_n)
    );

    nxe_seq #(.DW(DW), .NB(NB), .PULSE(PULSE)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .start   (start),
        .word    (tx_word),
        .nbytes  (nbytes),
        .phase   (phase),
        .dq_in   (nand_dq_in),
        .busy    (busy),
        .done    (done),
        .rx_word (rx_word),
        .cle     (nand_cle),
        .ale     (nand_ale),
        .we_n    (nand_we_n),
        .re_n    (nand_re_n),
        .dq_out  (nand_dq_out),
        .dq_oe   (nand_dq_oe)
    );

    // R6
    re_oe_chk: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    // R5
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

endmodule

// File: tb/test_nand_xfer_engine.sv
`timescale 1ns/100ps
module test_nand_xfer_engine;

    localparam int P = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic        reg_ready;
    logic [31:0] reg_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  dq_in_r = 8'h00;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nand_xfer_engine #(.DW(8), .NB(4), .PULSE(P)) i_nand_xfer_engine (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready),
        .reg_rdata(reg_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(dq_in_r)
    );

    function automatic logic [7:0] pat(int c);
        return 8'((c * 29 + 53) & 255);
    endfunction

    function automatic int tx_n(logic [7:0] a);
        case (a)
            8'h14: return 4;
            8'h18: return 1;
            8'h1C: return 2;
            8'h20: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // device side: next read byte presented on each falling read strobe
    int rcnt = 0;
    always @(negedge nand_re_n) if (!rst) begin
        rcnt = rcnt + 1;
        dq_in_r = pat(rcnt);
    end

    // behavioural reference model
    bit          m_en, m_busy, m_pend, m_rxv;
    logic [1:0]  m_cfg;
    logic [23:0] m_ctrl;
    int          m_t, m_n, m_rcnt, m_ph;
    logic [31:0] m_word, m_next, m_rxw;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_busy = 0; m_pend = 0; m_rxv = 0;
            m_cfg = 0; m_ctrl = 0; m_t = 0; m_n = 0; m_rcnt = 0; m_ph = 0;
            m_word = 0; m_next = 0; m_rxw = 0;
        end else begin
            if (!m_en) begin
                m_busy = 0; m_pend = 0; m_rxv = 0;
            end else begin
                if (m_pend) begin
                    m_rxv = 1; m_rxw = m_next; m_pend = 0;
                end else if (reg_rd && reg_addr == 8'h24) begin
                    m_rxv = 0;
                end
                if (m_busy) begin
                    m_t++;
                    if (m_t == 2 * P * m_n) begin m_busy = 0; m_pend = 1; end
                end else if (reg_wr && tx_n(reg_addr) != 0) begin
                    m_busy = 1; m_t = 0; m_n = tx_n(reg_addr); m_word = reg_wdata;
                    if (m_ctrl[1:0] == 2'd3)       m_ph = 0;
                    else if (m_ctrl[16:14] != 0)   m_ph = 1;
                    else if (m_ctrl[23])           m_ph = 3;
                    else                           m_ph = 2;
                    m_next = 0;
                    for (int i = 0; i < m_n; i++) begin
                        logic [7:0] b;
                        b = (m_ph == 3) ? pat(m_rcnt + 1 + i) : m_word[8*i +: 8];
                        m_next = {b, m_next[31:8]};
                    end
                    if (m_ph == 3) m_rcnt += m_n;
                end
            end
            if (reg_wr) begin
                if (reg_addr == 8'h00) m_cfg = reg_wdata[1:0];
                if (reg_addr == 8'h10) m_en = reg_wdata[0];
                if (reg_addr == 8'h30) m_ctrl = reg_wdata[23:0];
            end
        end
    end

    // per-clock pin comparison
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            bit low, rd, oe;
            int k;
            k   = m_t / (2 * P);
            rd  = m_busy && (m_ph == 3);
            low = m_busy && ((m_t % (2 * P)) < P);
            oe  = m_busy && !rd;
            chk("R10 ce_n", {31'h0, nand_ce_n}, {31'h0, !(m_cfg[1] && m_cfg[0])});
            chk("R5 cle", {31'h0, nand_cle}, {31'h0, m_busy && m_ph == 0});
            chk("R5 ale", {31'h0, nand_ale}, {31'h0, m_busy && m_ph == 1});
            chk("R4 we_n", {31'h0, nand_we_n}, {31'h0, !(low && !rd)});
            chk("R6 re_n", {31'h0, nand_re_n}, {31'h0, !(low && rd)});
            chk("R3 dq_oe", {31'h0, nand_dq_oe}, {31'h0, oe});
            if (oe) chk("R3 dq_out", {24'h0, nand_dq_out}, {24'h0, m_word[8*k +: 8]});
        end
    end

    task automatic reg_write(logic [7:0] a, logic [31:0] d, output int stalls);
        stalls = 0;
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        #1;
        while (!reg_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 0;
        while (!s[0]) reg_read(8'h04, s);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int st, c0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        reg_read(8'h04, d); chk("R1 status", d, 32'hB);
        reg_read(8'h10, d); chk("R1 enable", d, 32'h0);
        chk("R1 pins", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
            32'b111000);

        reg_write(8'h10, 32'h0, st);
        reg_write(8'h10, 32'h1, st);
        reg_write(8'h00, 32'h3, st);
        chk("R10 ce asserted", {31'h0, nand_ce_n}, 32'h0);

        // R5 command phase, 1 byte via 0x18 (R2)
        reg_write(8'h30, 32'h3, st);
        reg_write(8'h18, 32'hEEDDCCA5, st);
        reg_read(8'h04, d); chk("R8 busy status", d, 32'h8);
        wait_idle();
        reg_read(8'h04, d); chk("R8 rx waiting", d, 32'h7);
        reg_read(8'h24, d); chk("R7 cmd echo", d, 32'hA5000000);
        reg_read(8'h04, d); chk("R8 rx consumed", d, 32'hB);

        // R5 address phase, 3 bytes via 0x20 (R2)
        reg_write(8'h30, (32'd3 << 14) | (32'd3 << 3), st);
        reg_write(8'h20, 32'hDD332211, st);
        wait_idle();
        reg_read(8'h24, d); chk("R7 addr echo 3B", d, 32'h33221100);

        // data out 4 bytes, then a 2-byte word held off (R9)
        reg_write(8'h30, 32'd3 << 6, st);
        reg_write(8'h14, 32'h44332211, st);
        reg_write(8'h1C, 32'h0000BB66, st);
        chk("R9 held off", {31'h0, st > 0}, 32'h1);
        chk("R9 stall length", st, 2 * P * 4 - 1);
        wait_idle();
        reg_read(8'h24, d); chk("R7 dout echo 2B", d, 32'hBB660000);

        // R6 data in, 4 bytes then 1 byte
        reg_write(8'h30, (32'd1 << 23) | (32'd3 << 6), st);
        c0 = rcnt;
        reg_write(8'h14, 32'hFFFFFFFF, st);
        wait_idle();
        reg_read(8'h24, d);
        chk("R6 read word", d, {pat(c0 + 4), pat(c0 + 3), pat(c0 + 2), pat(c0 + 1)});
        chk("R7 model word", d, m_rxw);
        c0 = rcnt;
        reg_write(8'h18, 32'hFFFFFFFF, st);
        wait_idle();
        reg_read(8'h24, d); chk("R7 read 1B packed high", d, {pat(c0 + 1), 24'h0});

        // R10 chip enable needs both bits
        reg_write(8'h00, 32'h1, st);
        chk("R10 assert only", {31'h0, nand_ce_n}, 32'h1);
        reg_write(8'h00, 32'h2, st);
        chk("R10 manual only", {31'h0, nand_ce_n}, 32'h1);
        reg_write(8'h00, 32'h3, st);

        // R11 abort and ignore while disabled
        reg_write(8'h30, 32'd3 << 6, st);
        reg_write(8'h14, 32'h87654321, st);
        @(negedge clk);
        reg_write(8'h10, 32'h0, st);
        reg_read(8'h04, d); chk("R11 aborted idle", d, 32'hB);
        reg_write(8'h18, 32'h000000AA, st);
        repeat (6) @(negedge clk);
        reg_read(8'h04, d); chk("R11 write ignored", d, 32'hB);
        chk("R11 strobe idle", {31'h0, nand_we_n}, 32'h1);
        reg_write(8'h10, 32'h1, st);
        repeat (3) @(negedge clk);
        reg_read(8'h04, d); chk("R11 no restart", d, 32'hB);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule